// File: doc/BRIEF.md
# Interrupt Eligibility Mask Unit

This unit decides, for a bank of interrupt lines, which of them may be offered to a processor in the next cycle. For every line it combines a latched pending flag with the live input level (for level-configured lines). It then removes lines that are disabled or already active, and removes lines whose interrupt group is switched off by the global group enables. The result is a bit mask that a downstream priority picker consumes.

The group of a line comes from two configuration bits, a group bit and a modifier bit. With the group bit set, the line belongs to the non-secure group 1 class. With the group bit clear, the modifier picks between the secure group 1 class (modifier set) and group 0 (modifier clear). A global security-disable control makes every modifier read as zero, which folds the secure group 1 class into group 0. All lines are evaluated in parallel, and the mask is held in a register that updates on every rising clock edge.

Top module: `irq_elig_unit`

## Requirements
- R1: While `rst_n` is low, `elig_mask` is all zeros.
- R2: A line counts as pending when its `pend_latch` bit is 1, or when its `edge_cfg` bit is 0 (level mode) and its `line_lvl` bit is 1. An edge-mode line (`edge_cfg` = 1) with a high level and a clear latch is not eligible.
- R3: A line whose `enable_vec` bit is 0 is never eligible.
- R4: A line whose `active_vec` bit is 1 is never eligible.
- R5: A line with `group_vec` bit = 1 is non-secure group 1. It is eligible only while `en_g1ns` is 1.
- R6: While `sec_dis` is 0, a line with `group_vec` = 0 and `grpmod_vec` = 1 is secure group 1. It is eligible only while `en_g1s` is 1.
- R7: A line with `group_vec` = 0 and `grpmod_vec` = 0 is group 0. It is eligible only while `en_g0` is 1.
- R8: While `sec_dis` is 1, every modifier bit is treated as 0. A group-bit-0 line is then gated by `en_g0` alone, and `en_g1s` has no effect.
- R9: `elig_mask` at a rising edge takes the value computed from the inputs sampled at that edge. It is constant between edges and does not follow input changes until the next edge.
- R10: Each mask bit depends only on the same-index bits of the per-line vectors and on the four global controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_latch | input | NUM_LINES | Latched pending flag per line |
| edge_cfg | input | NUM_LINES | 1 = edge mode, 0 = level mode |
| line_lvl | input | NUM_LINES | Current input level per line |
| enable_vec | input | NUM_LINES | Per-line enable |
| active_vec | input | NUM_LINES | Per-line active flag |
| group_vec | input | NUM_LINES | Group bit per line |
| grpmod_vec | input | NUM_LINES | Group modifier bit per line |
| sec_dis | input | 1 | Security disable; forces modifiers to 0 |
| en_g0 | input | 1 | Group 0 enable |
| en_g1s | input | 1 | Secure group 1 enable |
| en_g1ns | input | 1 | Non-secure group 1 enable |
| elig_mask | output | NUM_LINES | Registered eligible mask |

## Verification
The two functions that can fall in the same cycle are pending formation and group gating. A level-mode line can be raised while its group is being switched off, and a latched line can become pending while security-disable moves it from the secure group 1 class into group 0. The bench drives such combined changes in a single cycle, with mixed group and modifier patterns across the bank and all sixteen settings of the global controls. A behavioural per-line model predicts the mask, and the bench compares it at every edge. It also checks that an input change made between edges does not reach the output early.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;

  typedef enum logic [1:0] {
    CLS_G0    = 2'd0,
    CLS_G1SEC = 2'd1,
    CLS_G1NS  = 2'd2
  } grp_class_t;

  // Pending if latched, or level mode with a high line.
  function automatic logic line_pending(input logic latch, input logic edge_mode,
                                        input logic lvl);
    return latch | (~edge_mode & lvl);
  endfunction

  // Class of a line; security disable forces the modifier to zero.
  function automatic grp_class_t line_class(input logic grp, input logic mdf,
                                            input logic sdis);
    if (grp) return CLS_G1NS;
    if (mdf & ~sdis) return CLS_G1SEC;
    return CLS_G0;
  endfunction

  function automatic logic class_allowed(input grp_class_t cls, input logic e0,
                                         input logic e1s, input logic e1ns);
    case (cls)
      CLS_G1NS:  return e1ns;
      CLS_G1SEC: return e1s;
      default:   return e0;
    endcase
  endfunction

endpackage

// File: rtl/irq_pend_stage.sv
module irq_pend_stage #(
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0] pend_latch,
  input  logic [NUM_LINES-1:0] edge_cfg,
  input  logic [NUM_LINES-1:0] line_lvl,
  input  logic [NUM_LINES-1:0] enable_vec,
  input  logic [NUM_LINES-1:0] active_vec,
  output logic [NUM_LINES-1:0] pend_mask,
  output logic [NUM_LINES-1:0] cand_mask
);
  import irq_elig_pkg::*;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign pend_mask[g] = line_pending(pend_latch[g], edge_cfg[g], line_lvl[g]);
    assign cand_mask[g] = pend_mask[g] & enable_vec[g] & ~active_vec[g];
  end
endmodule

// File: rtl/irq_group_gate.sv
module irq_group_gate #(
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0] group_vec,
  input  logic [NUM_LINES-1:0] grpmod_vec,
  input  logic                 sec_dis,
  input  logic                 en_g0,
  input  logic                 en_g1s,
  input  logic                 en_g1ns,
  output logic [NUM_LINES-1:0] grp_ok_mask
);
  import irq_elig_pkg::*;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    grp_class_t cls;
    assign cls            = line_class(group_vec[g], grpmod_vec[g], sec_dis);
    assign grp_ok_mask[g] = class_allowed(cls, en_g0, en_g1s, en_g1ns);
  end
endmodule

// File: rtl/irq_elig_unit.sv
module irq_elig_unit #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pend_latch,
  input  logic [NUM_LINES-1:0] edge_cfg,
  input  logic [NUM_LINES-1:0] line_lvl,
  input  logic [NUM_LINES-1:0] enable_vec,
  input  logic [NUM_LINES-1:0] active_vec,
  input  logic [NUM_LINES-1:0] group_vec,
  input  logic [NUM_LINES-1:0] grpmod_vec,
  input  logic                 sec_dis,
  input  logic                 en_g0,
  input  logic                 en_g1s,
  input  logic                 en_g1ns,
  output logic [NUM_LINES-1:0] elig_mask
);
  logic [NUM_LINES-1:0] pend_mask;
  logic [NUM_LINES-1:0] cand_mask;
  logic [NUM_LINES-1:0] grp_ok_mask;
  logic [NUM_LINES-1:0] next_mask;

  irq_pend_stage #(.NUM_LINES(NUM_LINES)) u_pend (
    .pend_latch (pend_latch),
    .edge_cfg   (edge_cfg),
    .line_lvl   (line_lvl),
    .enable_vec (enable_vec),
    .active_vec (active_vec),
    .pend_mask  (pend_mask),
    .cand_mask  (cand_mask)
  );

  irq_group_gate #(.NUM_LINES(NUM_LINES)) u_gate (
    .group_vec   (group_vec),
    .grpmod_vec  (grpmod_vec),
    .sec_dis     (sec_dis),
    .en_g0       (en_g0),
    .en_g1s      (en_g1s),
    .en_g1ns     (en_g1ns),
    .grp_ok_mask (grp_ok_mask)
  );

  assign next_mask = cand_mask & grp_ok_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_mask <= '0;
    else        elig_mask <= next_mask;
  end
endmodule

// File: rtl/irq_elig_checker.sv
module irq_elig_checker #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] pend_mask,
  input logic [NUM_LINES-1:0] enable_vec,
  input logic [NUM_LINES-1:0] active_vec,
  input logic [NUM_LINES-1:0] group_vec,
  input logic [NUM_LINES-1:0] grpmod_vec,
  input logic                 sec_dis,
  input logic                 en_g0,
  input logic                 en_g1s,
  input logic                 en_g1ns,
  input logic [NUM_LINES-1:0] next_mask,
  input logic [NUM_LINES-1:0] elig_mask
);
  logic [NUM_LINES-1:0] g1ns_lines, g1s_lines, g0_lines;
  assign g1ns_lines = group_vec;
  assign g1s_lines  = ~group_vec & (sec_dis ? '0 : grpmod_vec);
  assign g0_lines   = ~group_vec & ~(sec_dis ? '0 : grpmod_vec);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> elig_mask == '0);

  assert_pending_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (elig_mask & ~$past(pend_mask)) == '0);

  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (elig_mask & ~$past(enable_vec)) == '0);

  assert_active_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (elig_mask & $past(active_vec)) == '0);

  assert_g1ns_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_g1ns |=> (elig_mask & $past(g1ns_lines)) == '0);

  assert_g1s_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_g1s |=> (elig_mask & $past(g1s_lines)) == '0);

  assert_g0_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_g0 |=> (elig_mask & $past(g0_lines)) == '0);

  assert_secdis_fold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_dis && !en_g0) |=> (elig_mask & ~$past(group_vec)) == '0);

  assert_one_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> elig_mask == $past(next_mask));
endmodule

bind irq_elig_unit irq_elig_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pend_mask  (pend_mask),
  .enable_vec (enable_vec),
  .active_vec (active_vec),
  .group_vec  (group_vec),
  .grpmod_vec (grpmod_vec),
  .sec_dis    (sec_dis),
  .en_g0      (en_g0),
  .en_g1s     (en_g1s),
  .en_g1ns    (en_g1ns),
  .next_mask  (next_mask),
  .elig_mask  (elig_mask)
);

// File: tb/test_irq_elig_unit.sv
`timescale 1ns/1ps
module test_irq_elig_unit;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pend_latch = '0, edge_cfg = '0, line_lvl = '0, enable_vec = '0;
  logic [N-1:0] active_vec = '0, group_vec = '0, grpmod_vec = '0;
  logic         sec_dis = 1'b0, en_g0 = 1'b0, en_g1s = 1'b0, en_g1ns = 1'b0;
  logic [N-1:0] elig_mask;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] last_exp = '0;

  always #4 clk = ~clk;

  irq_elig_unit #(.NUM_LINES(N)) i_irq_elig_unit (
    .clk(clk), .rst_n(rst_n), .pend_latch(pend_latch), .edge_cfg(edge_cfg),
    .line_lvl(line_lvl), .enable_vec(enable_vec), .active_vec(active_vec),
    .group_vec(group_vec), .grpmod_vec(grpmod_vec), .sec_dis(sec_dis),
    .en_g0(en_g0), .en_g1s(en_g1s), .en_g1ns(en_g1ns), .elig_mask(elig_mask)
  );

  // Behavioural reference: one line at a time, stated from the requirements.
  function automatic logic [N-1:0] model();
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      bit is_pend, allowed;
      is_pend = (pend_latch[i] == 1'b1) || (edge_cfg[i] == 1'b0 && line_lvl[i] == 1'b1);
      if (!is_pend || !enable_vec[i] || active_vec[i]) continue;
      if (group_vec[i])                     allowed = en_g1ns;
      else if (grpmod_vec[i] && !sec_dis)   allowed = en_g1s;
      else                                  allowed = en_g0;
      r[i] = allowed;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs are set just after a falling edge; the result is sampled at the next falling edge.
  task automatic apply(string tag);
    #1;
    check("R9 hold before edge", elig_mask, last_exp);
    @(negedge clk);
    last_exp = model();
    check(tag, elig_mask, last_exp);
  endtask

  task automatic base_all_on();
    pend_latch = '1; edge_cfg = '0; line_lvl = '0; enable_vec = '1; active_vec = '0;
    group_vec = '0; grpmod_vec = '0; sec_dis = 0; en_g0 = 1; en_g1s = 1; en_g1ns = 1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pend_latch = '1; enable_vec = '1; en_g0 = 1; en_g1s = 1; en_g1ns = 1;
    @(negedge clk); @(negedge clk);
    check("R1 reset clear", elig_mask, '0);
    rst_n = 1'b1;
    last_exp = '0;

    // R2: latch vs level vs edge mode
    base_all_on();
    pend_latch = 32'h0000_00FF; edge_cfg = 32'h00FF_0F00; line_lvl = 32'h0F0F_0F0F;
    apply("R2 pending formation");
    pend_latch = '0; edge_cfg = '1; line_lvl = '1;
    apply("R2 edge mode level ignored");

    // R3 / R4
    base_all_on(); enable_vec = 32'h5555_AAAA;
    apply("R3 enable gate");
    base_all_on(); active_vec = 32'hF0F0_0001;
    apply("R4 active blocks");

    // R5 R6 R7: group classes
    base_all_on(); group_vec = 32'hFF00_0000; grpmod_vec = 32'h00FF_FF00;
    en_g1ns = 0; apply("R5 g1ns off");
    en_g1ns = 1; en_g1s = 0; apply("R6 g1s off");
    en_g1s = 1; en_g0 = 0; apply("R7 g0 off");

    // R8: security disable folds the modifier
    sec_dis = 1; en_g0 = 1; en_g1s = 0; apply("R8 secdis en_g1s ignored");
    en_g0 = 0; en_g1s = 1; apply("R8 secdis g0 gates folded lines");

    // R10: sweep all global control settings over a mixed bank
    pend_latch = 32'h1234_5678; edge_cfg = 32'h0F0F_3C3C; line_lvl = 32'hCAFE_BEEF;
    enable_vec = 32'hFFFE_7FFF; active_vec = 32'h0101_0808;
    group_vec = 32'h3333_CCCC; grpmod_vec = 32'h5A5A_A5A5;
    for (int c = 0; c < 16; c++) begin
      {sec_dis, en_g0, en_g1s, en_g1ns} = 4'(c);
      apply("R10 control sweep");
    end

    // Combined: level line rises while its group turns off, and secdis moves classes
    for (int k = 0; k < 300; k++) begin
      pend_latch = $urandom; edge_cfg = $urandom; line_lvl = $urandom;
      enable_vec = $urandom | $urandom; active_vec = $urandom & $urandom;
      group_vec = $urandom; grpmod_vec = $urandom;
      {sec_dis, en_g0, en_g1s, en_g1ns} = 4'($urandom);
      apply("R10 random mix");
    end

    // R1: reset mid-run clears the output
    base_all_on();
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", elig_mask, '0);
    @(negedge clk);
    check("R1 held in reset", elig_mask, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule